// File: doc/BRIEF.md
# Strobed-Latch Compute Wrapper

This block sits on a shared system bus beside a processor and a global sequencer. It holds a small compute kernel between a bank of input registers and a bank of output registers. There is no address decoder: every input and every output register has its own enable strobe, and the sequencer raises that strobe when the processor touches the address that belongs to it. Each input register captures the bus word on its strobe. Flags record which inputs have arrived, and once all of them are present a one-cycle ready pulse starts the kernel.

The example kernel is a wrapping adder. It sums all inputs and, after a parameterised latency, writes one result per output register. Output `j` holds the total minus input `j`. Completion is then held high until every output register has been read once through its enable. That read-out releases the wrapper for the next set of inputs. The output path has no tri-state driver: a multiplexed word and a valid flag, both zero when no output strobe is active.

Top module: `hs_module_wrap`

## Requirements
- R1: An active-low asynchronous reset clears every input and output register, every loaded and read flag, `ready_o` and `done_o`. After reset, reading any output gives 0 and earlier input writes do not count toward ready.
- R2: While the wrapper is collecting (neither busy nor done), a high `in_en_i[i]` at a clock edge stores `bus_data_i` into input register `i` and marks that input as loaded.
- R3: `ready_o` is low while any input is still unloaded. It is high in the cycle right after the edge that loads the last missing input.
- R4: The edge that ends the ready cycle starts the kernel. `done_o` stays low for the next `LATENCY` cycles and is first high in cycle `LATENCY+1`, counting the ready cycle as cycle 0.
- R5: When `done_o` rises, output register `j` holds (sum of all `NUM_PORTS` inputs − input `j`) modulo 2^`DATA_W`.
- R6: While `out_en_i` has bit `j` set (one-hot), `bus_data_o` equals output register `j` and `bus_valid_o` is 1 in the same cycle. With `out_en_i` all zero, both outputs are 0.
- R7: `done_o` stays high until every output register has been strobed at least once while done. The edge that samples the last outstanding strobe clears `done_o` and all loaded flags, so the next computation needs a fresh write to every input.
- R8: Input strobes while the kernel is busy or done change neither the input registers nor the loaded flags.
- R9: Output registers keep their values after `done_o` clears and while the next computation runs. Only the next completion overwrites them.
- R10: `ready_o` is high for exactly one cycle per computation and is never high together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | DATA_W | Bus write data |
| in_en_i | input | NUM_PORTS | Per-input load strobes |
| out_en_i | input | NUM_PORTS | Per-output read strobes, at most one high |
| ready_o | output | 1 | All inputs present; kernel start pulse |
| done_o | output | 1 | Results valid and not yet fully read |
| bus_data_o | output | DATA_W | Selected output register, zero when idle |
| bus_valid_o | output | 1 | An output strobe is active |

## Verification
The checks assume that the sequencer never raises more than one output strobe at a time; a dedicated assertion flags any breach of that. They also assume that no input strobe coincides with the one-cycle ready window. The bench drives each strobe for exactly one cycle, between falling edges, and always one bit at a time. Its stray writes fall only in the busy or done phases, which is where R8 says they must be dropped. Latency is timed by a counter in the checker that runs from the ready pulse, so large `LATENCY` values do not call for deep history.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_BUSY    = 2'd1,
    PH_DONE    = 2'd2
  } phase_e;
endpackage

// File: rtl/hsw_in_bank.sv
module hsw_in_bank #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [DATA_W-1:0]                 bus_data_i,
  input  logic [NUM_PORTS-1:0]              in_en_i,
  input  logic                              accept_i,
  input  logic                              clear_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  opnd_o,
  output logic                              all_loaded_o
);
  logic [NUM_PORTS-1:0] loaded_q;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        opnd_o[g]   <= '0;
        loaded_q[g] <= 1'b0;
      end else if (clear_i) begin
        loaded_q[g] <= 1'b0;
      end else if (accept_i && in_en_i[g]) begin
        opnd_o[g]   <= bus_data_i;
        loaded_q[g] <= 1'b1;
      end
    end
  end

  assign all_loaded_o = &loaded_q;
endmodule

// File: rtl/hsw_sum_kernel.sv
module hsw_sum_kernel #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int LATENCY   = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  opnd_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  result_o,
  output logic                              fin_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] total_d, total_q;

  always_comb begin
    total_d = '0;
    for (int j = 0; j < NUM_PORTS; j++) total_d = total_d + opnd_i[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      total_q <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      cnt_q   <= CNT_W'(LATENCY);
      total_q <= total_d;
    end else if (run_q) begin
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign fin_o = run_q && (cnt_q == CNT_W'(1));

  // operands are frozen while running, so per-port results derive from them
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_res
    assign result_o[g] = total_q - opnd_i[g];
  end
endmodule

// File: rtl/hsw_out_bank.sv
module hsw_out_bank #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  result_i,
  input  logic [NUM_PORTS-1:0]              out_en_i,
  input  logic                              track_i,
  output logic [DATA_W-1:0]                 bus_data_o,
  output logic                              bus_valid_o,
  output logic                              drain_o
);
  logic [NUM_PORTS-1:0][DATA_W-1:0] res_q;
  logic [NUM_PORTS-1:0]             read_q;

  assign drain_o = track_i && (&(read_q | out_en_i));

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q[g]  <= '0;
        read_q[g] <= 1'b0;
      end else if (load_i) begin
        res_q[g]  <= result_i[g];
        read_q[g] <= 1'b0;
      end else if (drain_o) begin
        read_q[g] <= 1'b0;
      end else if (track_i && out_en_i[g]) begin
        read_q[g] <= 1'b1;
      end
    end
  end

  // lowest enabled index wins if strobes ever overlap
  always_comb begin
    bus_data_o = '0;
    for (int j = NUM_PORTS - 1; j >= 0; j--) begin
      if (out_en_i[j]) bus_data_o = res_q[j];
    end
  end

  assign bus_valid_o = |out_en_i;
endmodule

// File: rtl/hs_module_wrap.sv
module hs_module_wrap
  import hsw_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int LATENCY   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    bus_data_i,
  input  logic [NUM_PORTS-1:0] in_en_i,
  input  logic [NUM_PORTS-1:0] out_en_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    bus_data_o,
  output logic                 bus_valid_o
);
  phase_e phase_q, phase_d;

  logic [NUM_PORTS-1:0][DATA_W-1:0] opnd, result;
  logic all_loaded, fin, drain;

  hsw_in_bank #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_in (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_data_i   (bus_data_i),
    .in_en_i      (in_en_i),
    .accept_i     (phase_q == PH_COLLECT),
    .clear_i      (drain),
    .opnd_o       (opnd),
    .all_loaded_o (all_loaded)
  );

  hsw_sum_kernel #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .LATENCY(LATENCY)) u_kern (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ready_o),
    .opnd_i   (opnd),
    .result_o (result),
    .fin_o    (fin)
  );

  hsw_out_bank #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (fin),
    .result_i    (result),
    .out_en_i    (out_en_i),
    .track_i     (phase_q == PH_DONE),
    .bus_data_o  (bus_data_o),
    .bus_valid_o (bus_valid_o),
    .drain_o     (drain)
  );

  assign ready_o = (phase_q == PH_COLLECT) && all_loaded;
  assign done_o  = (phase_q == PH_DONE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_COLLECT: if (ready_o) phase_d = PH_BUSY;
      PH_BUSY:    if (fin)     phase_d = PH_DONE;
      PH_DONE:    if (drain)   phase_d = PH_COLLECT;
      default:                 phase_d = PH_COLLECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_COLLECT;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/hsw_wrap_chk.sv
module hsw_wrap_chk #(
  parameter int NUM_PORTS = 4,
  parameter int LATENCY   = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PORTS-1:0] out_en_i,
  input logic                 ready_o,
  input logic                 done_o,
  input logic                 bus_valid_o,
  input logic                 bus_is_zero
);
  int unsigned since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      since_q <= 0;
    else if (ready_o)                 since_q <= 1;
    else if (since_q != 0 && !done_o) since_q <= since_q + 1;
  end

  // input rule: sequencer strobes at most one output
  out_en_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_en_i));

  // R10
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R10
  ready_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o));

  // R4
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> since_q == LATENCY + 1);

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && out_en_i == '0) |=> done_o);

  // R6
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i == '0) |-> (!bus_valid_o && bus_is_zero));
endmodule

bind hs_module_wrap hsw_wrap_chk #(.NUM_PORTS(NUM_PORTS), .LATENCY(LATENCY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_en_i    (out_en_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .bus_valid_o (bus_valid_o),
  .bus_is_zero (bus_data_o == '0)
);

// File: tb/hs_module_wrap_test.sv
`timescale 1ns/1ps
module hs_module_wrap_test;
  localparam int NP  = 4;
  localparam int DW  = 16;
  localparam int LAT = 4;
  localparam int NV  = 5;
  // each entry: four 16-bit inputs, input i at bits [16*i +: 16]
  localparam logic [NP*DW-1:0] VECS [NV] = '{
    64'h0004_0003_0002_0001,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000,
    64'h8000_7FFF_1234_ABCD,
    64'h00FF_FF00_0F0F_F0F0
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DW-1:0] bus_data_i = '0;
  logic [NP-1:0] in_en_i = '0;
  logic [NP-1:0] out_en_i = '0;
  logic ready_o, done_o, bus_valid_o;
  logic [DW-1:0] bus_data_o;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hs_module_wrap #(.NUM_PORTS(NP), .DATA_W(DW), .LATENCY(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_data_i(bus_data_i), .in_en_i(in_en_i),
    .out_en_i(out_en_i), .ready_o(ready_o), .done_o(done_o),
    .bus_data_o(bus_data_o), .bus_valid_o(bus_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_out(input logic [NP*DW-1:0] v, input int j);
    logic [DW-1:0] s = '0;
    for (int i = 0; i < NP; i++) if (i != j) s = s + v[i*DW +: DW];
    return s;
  endfunction

  task automatic write_in(input int i, input logic [DW-1:0] d);
    @(negedge clk);
    bus_data_i = d;
    in_en_i = '0;
    in_en_i[i] = 1'b1;
    @(negedge clk);
    in_en_i = '0;
  endtask

  task automatic read_out(input int j, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    out_en_i = '0;
    out_en_i[j] = 1'b1;
    #2;
    d = bus_data_o;
    v = bus_valid_o;
    @(negedge clk);
    out_en_i = '0;
  endtask

  task automatic load_all(input logic [NP*DW-1:0] v, input bit rev);
    for (int n = 0; n < NP; n++) begin
      int i = rev ? NP - 1 - n : n;
      write_in(i, v[i*DW +: DW]);
      if (n < NP - 1) chk("R3 ready early", ready_o, 0);
    end
    chk("R3 ready after last load", ready_o, 1);
  endtask

  // called in the ready cycle; poke writes junk into input 0 while busy
  task automatic finish_round(input logic [NP*DW-1:0] v, input bit poke);
    logic [DW-1:0] d;
    logic vv;
    for (int n = 1; n <= LAT; n++) begin
      @(negedge clk);
      in_en_i = '0;
      chk("R10 ready single cycle", ready_o, 0);
      chk("R4 done early", done_o, 0);
      if (poke && n == 1) begin
        bus_data_i = 16'hDEAD;
        in_en_i[0] = 1'b1;
      end
    end
    @(negedge clk);
    in_en_i = '0;
    chk("R4 done at latency", done_o, 1);
    for (int j = 0; j < NP; j++) begin
      read_out(j, d, vv);
      chk(poke ? "R8 busy write ignored" : "R5 result", d, expect_out(v, j));
      chk("R6 valid on read", vv, 1);
      if (j < NP - 1) chk("R7 done held", done_o, 1);
    end
    chk("R7 done cleared after reads", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic vv;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 ready after reset", ready_o, 0);
    chk("R1 done after reset", done_o, 0);
    read_out(2, d, vv);
    chk("R1 output cleared", d, 0);
    // R6 idle bus
    #2;
    chk("R6 idle valid", bus_valid_o, 0);
    chk("R6 idle data", bus_data_o, 0);

    // R2 R5: vector table
    for (int v = 0; v < NV; v++) begin
      load_all(VECS[v], v % 2 == 1);
      finish_round(VECS[v], 1'b0);
    end

    // R9: output registers retained after done clears
    read_out(1, d, vv);
    chk("R9 retained after drain", d, expect_out(VECS[NV-1], 1));
    chk("R9 done stays low", done_o, 0);

    // R8: write while busy is dropped
    load_all(VECS[0], 1'b0);
    finish_round(VECS[0], 1'b1);

    // R8 R7: write while done is dropped; flags cleared after drain
    load_all(VECS[3], 1'b0);
    for (int n = 1; n <= LAT + 1; n++) @(negedge clk);
    chk("R4 done before junk", done_o, 1);
    write_in(2, 16'h5555);
    for (int j = 0; j < NP; j++) begin
      read_out(j, d, vv);
      chk("R8 done write ignored", d, expect_out(VECS[3], j));
    end
    for (int i = 1; i < NP; i++) write_in(i, VECS[2][i*DW +: DW]);
    chk("R7 flags cleared, ready low", ready_o, 0);
    write_in(0, VECS[2][DW-1:0]);
    chk("R3 ready after refill", ready_o, 1);
    finish_round(VECS[2], 1'b0);

    // R1: reset mid-collection
    write_in(0, 16'h1111);
    write_in(1, 16'h2222);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    write_in(2, 16'h3333);
    write_in(3, 16'h4444);
    chk("R1 loaded flags cleared", ready_o, 0);
    read_out(0, d, vv);
    chk("R1 outputs cleared", d, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule